// File: doc/BRIEF.md
# Ballot Cast-or-Challenge Controller

This block runs the closing step of a voting session. An encryption engine hands it one encrypted ballot at a time, together with the random nonce that was used to encrypt that ballot. The block holds both values and offers the voter two choices, shown through the `choice_open` flag. The voter answers with one of two debounced button pulses.

A cast commits the ciphertext to the outgoing record, and the ballot counts. A challenge voids the ballot and publishes only its encryption nonce, so an auditor can re-encrypt the ballot and compare the result. No port of this block ever carries a signing or decryption key. Records leave as a byte stream with valid/ready flow control. Each record is a one-byte type tag followed by its payload, most significant byte first.

After either record has been sent, one clearing cycle wipes the held ciphertext and nonce. Only after that cycle is the next ballot accepted, so a nonce never outlives its ballot.

Top module: `ballot_choice_ctrl`

## Requirements
- R1: After synchronous active-low reset, `in_ready` is 1, `choice_open` is 0 and `out_valid` is 0.
- R2: A ballot is taken only on a cycle with `in_valid` and `in_ready` both high. `in_ready` is low from acceptance until the clearing cycle has ended, which covers the choice wait, record emission and clearing.
- R3: From the cycle after acceptance, `choice_open` stays high until a button press is acted on.
- R4: A cast press alone in the choice wait produces a record of 1 + CT_BYTES bytes. The first byte is tag 0x01, followed by the ciphertext most significant byte first. `out_last` is high only on the final byte.
- R5: A challenge press alone in the choice wait produces a record of 1 + NONCE_BYTES bytes. The first byte is tag 0x02, followed by the nonce most significant byte first. `out_last` is high only on the final byte.
- R6: If both buttons are high in the same cycle, neither press is acted on. `choice_open` stays high and no record starts.
- R7: Button pulses are ignored outside the choice wait: while idle, while a record is being sent and during clearing. Record content and length are unchanged by them.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold, and no byte is skipped.
- R9: The handshake of the final byte is followed by exactly one cycle with `in_ready` and `out_valid` both low. During that cycle the held nonce is zeroed. `in_ready` rises in the next cycle.
- R10: A record carries only its tag and the selected payload, and `out_valid` is low once the final byte has been taken. A cast record never contains the nonce.
- R11: A challenge discloses the nonce of the ballot loaded most recently, never a nonce from an earlier ballot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Encrypted ballot offered by the engine |
| in_ready | output | 1 | Block can take a ballot |
| in_ct | input | 8*CT_BYTES | Ballot ciphertext |
| in_nonce | input | 8*NONCE_BYTES | Encryption nonce of that ballot |
| btn_cast | input | 1 | Debounced cast pulse |
| btn_chal | input | 1 | Debounced challenge pulse |
| choice_open | output | 1 | Voter choice is being awaited |
| out_valid | output | 1 | Record byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Record byte |
| out_last | output | 1 | Final byte of the record |

## Verification
The bench builds the controller with CT_BYTES = 6 and NONCE_BYTES = 3. These values are short enough to stall the stream at every byte position of both record kinds. They are also unequal, so a framer that swaps the two lengths or payloads produces a record of the wrong size. Back-to-back ballots with different nonces bring within reach both the clearing cycle and the rule that a challenge discloses the current nonce.

// File: rtl/ballot_choice_pkg.sv
// Shared types for the ballot cast-or-challenge controller.
// Assumes: record tags are one byte and fixed by the record format.
package ballot_choice_pkg;

    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_AWAIT     = 3'd1,
        PH_EMIT_CAST = 3'd2,
        PH_EMIT_CHAL = 3'd3,
        PH_CLEAR     = 3'd4
    } phase_t;

    typedef enum logic {
        REC_CAST = 1'b0,
        REC_CHAL = 1'b1
    } rec_kind_t;

    localparam logic [7:0] TAG_CAST = 8'h01;
    localparam logic [7:0] TAG_CHAL = 8'h02;

endpackage

// File: rtl/ballot_store.sv
// Holds the ciphertext and nonce of the ballot in progress.
// Assumes: load and wipe are never high together (the sequencer guarantees it).
module ballot_store #(
    parameter int CT_BYTES    = 16,
    parameter int NONCE_BYTES = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic                         wipe,
    input  logic [CT_BYTES*8-1:0]        ct_in,
    input  logic [NONCE_BYTES*8-1:0]     nonce_in,
    output logic [CT_BYTES-1:0][7:0]     ct_q,
    output logic [NONCE_BYTES-1:0][7:0]  nonce_q
);

    // Capture a new ballot, or zero both buffers when wiping.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            ct_q    <= '0;
            nonce_q <= '0;
        end else if (load) begin
            ct_q    <= ct_in;
            nonce_q <= nonce_in;
        end
    end

endmodule

// File: rtl/choice_seq.sv
// Phase sequencer: accept a ballot, wait for exactly one button, emit, clear.
// Assumes: buttons are single-cycle debounced pulses; emit_done is a one-cycle pulse.
module choice_seq
    import ballot_choice_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic      btn_cast,
    input  logic      btn_chal,
    input  logic      emit_done,
    output logic      in_ready,
    output logic      load,
    output logic      choice_open,
    output logic      emit_active,
    output rec_kind_t emit_kind,
    output logic      wipe
);

    phase_t ph_q, ph_d;

    // Next-phase selection; presses count only in the choice wait and only if exclusive.
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:      if (in_valid) ph_d = PH_AWAIT;
            PH_AWAIT: begin
                if (btn_cast && !btn_chal)      ph_d = PH_EMIT_CAST;
                else if (btn_chal && !btn_cast) ph_d = PH_EMIT_CHAL;
            end
            PH_EMIT_CAST: if (emit_done) ph_d = PH_CLEAR;
            PH_EMIT_CHAL: if (emit_done) ph_d = PH_CLEAR;
            PH_CLEAR:     ph_d = PH_IDLE;
            default:      ph_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // Decoded controls for the store and the framer.
    always_comb begin
        in_ready    = (ph_q == PH_IDLE);
        load        = in_ready && in_valid;
        choice_open = (ph_q == PH_AWAIT);
        emit_active = (ph_q == PH_EMIT_CAST) || (ph_q == PH_EMIT_CHAL);
        emit_kind   = (ph_q == PH_EMIT_CHAL) ? REC_CHAL : REC_CAST;
        wipe        = (ph_q == PH_CLEAR);
    end

    // R6
    both_pressed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_AWAIT && btn_cast && btn_chal) |=> (ph_q == PH_AWAIT));

    // R7
    idle_ignores_buttons_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_IDLE && !in_valid) |=> (ph_q == PH_IDLE));

    // R9
    clear_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_CLEAR) |=> (ph_q == PH_IDLE));

endmodule

// File: rtl/record_framer.sv
// Serialises a record: type tag, then the selected payload, most significant byte first.
// Assumes: payload buffers stay stable while active is high.
module record_framer
    import ballot_choice_pkg::*;
#(
    parameter int CT_BYTES    = 16,
    parameter int NONCE_BYTES = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         active,
    input  rec_kind_t                    kind,
    input  logic [CT_BYTES-1:0][7:0]     ct_q,
    input  logic [NONCE_BYTES-1:0][7:0]  nonce_q,
    input  logic                         out_ready,
    output logic                         out_valid,
    output logic [7:0]                   out_data,
    output logic                         out_last,
    output logic                         done
);

    localparam int LEN_CT  = 1 + CT_BYTES;
    localparam int LEN_CH  = 1 + NONCE_BYTES;
    localparam int LEN_MAX = (LEN_CT > LEN_CH) ? LEN_CT : LEN_CH;
    localparam int IDX_W   = $clog2(LEN_MAX + 1);

    logic [IDX_W-1:0] idx_q;
    int               rec_len;

    // Record length for the selected kind.
    always_comb rec_len = (kind == REC_CHAL) ? LEN_CH : LEN_CT;

    // Byte selection: tag at position zero, then payload from the top byte down.
    always_comb begin
        out_data = 8'h00;
        if (idx_q == '0) begin
            out_data = (kind == REC_CHAL) ? TAG_CHAL : TAG_CAST;
        end else if (kind == REC_CHAL) begin
            for (int b = 0; b < NONCE_BYTES; b++)
                if (int'(idx_q) == NONCE_BYTES - b) out_data = nonce_q[b];
        end else begin
            for (int b = 0; b < CT_BYTES; b++)
                if (int'(idx_q) == CT_BYTES - b) out_data = ct_q[b];
        end
    end

    // Handshake outputs.
    always_comb begin
        out_valid = active;
        out_last  = active && (int'(idx_q) == rec_len - 1);
        done      = out_last && out_ready;
    end

    // Byte position: advance on each accepted byte, rewind after the last.
    always_ff @(posedge clk) begin
        if (!rst_n)                     idx_q <= '0;
        else if (active && out_ready)   idx_q <= out_last ? '0 : idx_q + 1'b1;
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R4
    cast_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && idx_q == '0 && kind == REC_CAST) |-> (out_data == 8'h01));

    // R5
    chal_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && idx_q == '0 && kind == REC_CHAL) |-> (out_data == 8'h02));

endmodule

// File: rtl/ballot_choice_ctrl.sv
// Top: final-step controller offering cast or challenge for each encrypted ballot.
// Assumes: the engine supplies a fresh nonce with each ballot; no key enters this block.
module ballot_choice_ctrl
    import ballot_choice_pkg::*;
#(
    parameter int CT_BYTES    = 16,
    parameter int NONCE_BYTES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [CT_BYTES*8-1:0]     in_ct,
    input  logic [NONCE_BYTES*8-1:0]  in_nonce,
    input  logic                      btn_cast,
    input  logic                      btn_chal,
    output logic                      choice_open,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [7:0]                out_data,
    output logic                      out_last
);

    logic                         load, wipe, emit_active, emit_done;
    rec_kind_t                    emit_kind;
    logic [CT_BYTES-1:0][7:0]     ct_q;
    logic [NONCE_BYTES-1:0][7:0]  nonce_q;

    choice_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .btn_cast    (btn_cast),
        .btn_chal    (btn_chal),
        .emit_done   (emit_done),
        .in_ready    (in_ready),
        .load        (load),
        .choice_open (choice_open),
        .emit_active (emit_active),
        .emit_kind   (emit_kind),
        .wipe        (wipe)
    );

    ballot_store #(.CT_BYTES(CT_BYTES), .NONCE_BYTES(NONCE_BYTES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .wipe     (wipe),
        .ct_in    (in_ct),
        .nonce_in (in_nonce),
        .ct_q     (ct_q),
        .nonce_q  (nonce_q)
    );

    record_framer #(.CT_BYTES(CT_BYTES), .NONCE_BYTES(NONCE_BYTES)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (emit_active),
        .kind      (emit_kind),
        .ct_q      (ct_q),
        .nonce_q   (nonce_q),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .done      (emit_done)
    );

    // R9
    nonce_wiped_before_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (nonce_q == '0));

    // R2
    no_accept_while_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R10
    nothing_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last && out_ready) |=> !out_valid);

endmodule

// File: tb/tb_ballot_choice_ctrl.sv
module tb_ballot_choice_ctrl;

    localparam int CTB = 6;
    localparam int NB  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [CTB*8-1:0] in_ct = '0;
    logic [NB*8-1:0]  in_nonce = '0;
    logic            btn_cast = 1'b0;
    logic            btn_chal = 1'b0;
    logic            choice_open;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [7:0]      out_data;
    logic            out_last;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [7:0] exp_b [0:15];
    int         exp_n;

    always #4 clk = ~clk;

    ballot_choice_ctrl #(.CT_BYTES(CTB), .NONCE_BYTES(NB)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ct(in_ct), .in_nonce(in_nonce), .btn_cast(btn_cast), .btn_chal(btn_chal),
        .choice_open(choice_open), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input bit ok, input string rq, input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    // Expected record: tag then payload, top byte first.
    task automatic build_cast(input logic [CTB*8-1:0] ct);
        exp_b[0] = 8'h01;
        for (int i = 0; i < CTB; i++) exp_b[1+i] = ct[(CTB-1-i)*8 +: 8];
        exp_n = 1 + CTB;
    endtask

    task automatic build_chal(input logic [NB*8-1:0] nn);
        exp_b[0] = 8'h02;
        for (int i = 0; i < NB; i++) exp_b[1+i] = nn[(NB-1-i)*8 +: 8];
        exp_n = 1 + NB;
    endtask

    task automatic load_ballot(input logic [CTB*8-1:0] ct, input logic [NB*8-1:0] nn);
        @(negedge clk);
        check(in_ready == 1'b1, "R2 ready before load", in_ready, 1);
        in_valid = 1'b1; in_ct = ct; in_nonce = nn;
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R2 ready low after load", in_ready, 0);
        check(choice_open == 1'b1, "R3 choice open", choice_open, 1);
    endtask

    task automatic press(input logic c, input logic h);
        @(negedge clk);
        btn_cast = c; btn_chal = h;
        @(negedge clk);
        btn_cast = 1'b0; btn_chal = 1'b0;
    endtask

    // Collect one record; stall=1 alternates out_ready, noisy drives buttons and in_valid.
    task automatic collect(input bit stall, input bit noisy, input string rq);
        int got = 0;
        int guard = 0;
        logic [7:0] prev_d = 8'h00;
        logic prev_l = 1'b0;
        bit stalled = 1'b0;
        while (got < exp_n && guard < 100) begin
            @(negedge clk);
            guard++;
            if (stalled) begin
                check(out_valid && out_data == prev_d && out_last == prev_l,
                      "R8 held under stall", out_data, prev_d);
            end
            if (noisy) begin btn_chal = 1'b1; btn_cast = 1'b1; in_valid = 1'b1; end
            out_ready = stall ? (guard % 2 == 0) : 1'b1;
            check(in_ready == 1'b0, "R2 no accept during emit", in_ready, 0);
            if (out_valid && out_ready) begin
                check(out_data == exp_b[got], rq, out_data, exp_b[got]);
                check(out_last == (got == exp_n - 1), "R10 last flag", out_last, got == exp_n - 1);
                got++;
                stalled = 1'b0;
            end else if (out_valid) begin
                stalled = 1'b1;
                prev_d = out_data;
                prev_l = out_last;
            end
        end
        check(got == exp_n, "R10 record length", got, exp_n);
        @(negedge clk);
        btn_chal = 1'b0; btn_cast = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        check(out_valid == 1'b0, "R10 nothing after last", out_valid, 0);
        check(in_ready == 1'b0, "R9 clearing cycle", in_ready, 0);
        @(negedge clk);
        check(in_ready == 1'b1, "R9 ready after clear", in_ready, 1);
        check(out_valid == 1'b0, "R7 no record from noise", out_valid, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        check(choice_open == 1'b0, "R1 choice_open", choice_open, 0);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    endtask

    task automatic t_idle_buttons();
        press(1'b1, 1'b0);
        press(1'b0, 1'b1);
        @(negedge clk);
        check(out_valid == 1'b0, "R7 idle cast ignored", out_valid, 0);
        check(choice_open == 1'b0, "R7 idle no choice", choice_open, 0);
        check(in_ready == 1'b1, "R7 idle stays ready", in_ready, 1);
    endtask

    task automatic t_cast(input logic [CTB*8-1:0] ct, input logic [NB*8-1:0] nn, input bit stall);
        load_ballot(ct, nn);
        build_cast(ct);
        press(1'b1, 1'b0);
        collect(stall, 1'b0, "R4 cast byte");
    endtask

    task automatic t_chal(input logic [CTB*8-1:0] ct, input logic [NB*8-1:0] nn, input bit stall);
        load_ballot(ct, nn);
        build_chal(nn);
        press(1'b0, 1'b1);
        collect(stall, 1'b0, "R5 R11 challenge byte");
    endtask

    task automatic t_both();
        load_ballot(48'hA1A2A3A4A5A6, 24'h5C5D5E);
        press(1'b1, 1'b1);
        check(choice_open == 1'b1, "R6 still waiting", choice_open, 1);
        check(out_valid == 1'b0, "R6 no record", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b0, "R6 no record later", out_valid, 0);
        build_chal(24'h5C5D5E);
        press(1'b0, 1'b1);
        collect(1'b0, 1'b0, "R6 challenge after both");
    endtask

    task automatic t_emit_noise();
        load_ballot(48'h0F1E2D3C4B5A, 24'h778899);
        build_cast(48'h0F1E2D3C4B5A);
        press(1'b1, 1'b0);
        collect(1'b1, 1'b1, "R7 cast byte under noise");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle_buttons();
        t_cast(48'h112233445566, 24'hABCDEF, 1'b0);
        t_chal(48'hCAFEBABE0102, 24'h13579B, 1'b0);
        t_cast(48'hDEADBEEF7788, 24'h2468AC, 1'b1);
        t_chal(48'h0102030405FF, 24'hFEDCBA, 1'b1);
        t_both();
        t_emit_noise();
        t_chal(48'h999999999999, 24'h010203, 1'b0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule